// File: doc/BRIEF.md
# Virtual Processor Execution Sequencer

This block controls the execution cluster of one lane in a lane-striped vector-thread unit. It takes execute directives from the lane's command queue and reads the named instruction block from the block cache, one word per cycle. Each word goes either to the functional units as an issued operation or, if it is a thread-fetch, back to the command manager. The block cache has a combinational read port. A vector directive repeats the whole block once for every virtual processor (VP) that this lane holds below the vector length. VPs are handled one after another, and each finishes the whole block before the next one starts. A single-VP directive runs the block once for one named VP.

VP numbers are striped over the lanes. Lane `LANE_ID` holds VPs `LANE_ID`, `LANE_ID+NUM_LANES`, and so on. The local slot of a VP is its number divided by `NUM_LANES`. The physical register file of the cluster has two regions. A common shared region sits at the bottom and holds scratch values that any VP may overwrite. Above it, each local slot has its own private window. Configuration inputs set the size of both regions and the vector length. From these the block derives the largest vector length the register file can hold, and it clamps vector directives to that limit.

Top module: `vp_exec_seq`

## Requirements
- R1: After reset, `dir_ready` is 1 and `iss_valid`, `tf_valid` and `dir_done` are 0.
- R2: A directive is accepted on a cycle with `dir_valid` and `dir_ready` both high. From the next cycle, `bc_addr` starts at `dir_block` and moves up by one per cycle. It stops at the word whose stop bit (bit 19) is set, so each instruction takes exactly one cycle.
- R3: A vector directive runs the block for VP numbers `LANE_ID + k*NUM_LANES`, with k counting up from 0 over every such number below the effective vector length. Every instruction of the block completes for one VP before the next VP begins, and `bc_addr` goes back to the block start for each new VP.
- R4: A single-VP directive runs the block exactly once, for VP `dir_vp`. Every operation reports that VP number.
- R5: A virtual register index r below `cfg_shared` maps to physical register r, whatever the VP.
- R6: A virtual register index r at or above `cfg_shared` maps to physical register `cfg_shared + k*cfg_private + (r - cfg_shared)`, where k = VP number / `NUM_LANES`. The destination index is word bits 17:13 and the source index is bits 12:8.
- R7: A word with the thread-fetch bit (bit 18) set raises `tf_valid` with the current VP and the target block from bits 7:0. It does not raise `iss_valid`. Any other word raises `iss_valid` and not `tf_valid`.
- R8: `max_vlen` equals `NUM_LANES * min((32 - cfg_shared) / cfg_private, MAX_VP / NUM_LANES)`, or `MAX_VP` when `cfg_private` is 0. A vector directive runs as if the vector length were `min(cfg_vlen, max_vlen)`.
- R9: `dir_done` pulses for one cycle, together with the last instruction of the last VP. A vector directive that holds no VPs on this lane pulses `dir_done` in the cycle after acceptance and issues nothing.
- R10: `dir_ready` is low while a directive runs and is high again in the cycle after `dir_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_shared | input | 6 | Number of shared registers |
| cfg_private | input | 6 | Private registers per VP |
| cfg_vlen | input | 8 | Requested vector length |
| max_vlen | output | 8 | Largest vector length the register split can hold |
| dir_valid | input | 1 | A directive is waiting |
| dir_ready | output | 1 | Sequencer idle, directive is popped |
| dir_vector | input | 1 | 1: vector directive, 0: single-VP directive |
| dir_vp | input | 7 | VP number for a single-VP directive |
| dir_block | input | 8 | Block cache address of the first word |
| bc_addr | output | 8 | Block cache read address |
| bc_word | input | 20 | Instruction word read at `bc_addr` |
| iss_valid | output | 1 | Operation issued to the functional units |
| iss_vp | output | 7 | VP of the issued operation |
| iss_dst | output | 5 | Physical destination register |
| iss_src | output | 5 | Physical source register |
| tf_valid | output | 1 | Thread-fetch request to the command manager |
| tf_vp | output | 7 | VP whose pending fetch is updated |
| tf_block | output | 8 | Requested block address |
| dir_done | output | 1 | Last instruction of the directive |

## Verification
The checker assumes three things about the inputs. The configuration stays stable while a directive runs. A single-VP directive names a VP that belongs to this lane. Every block in the cache ends with a stop word before the address wraps. The bench changes configuration only while the sequencer is idle. It draws single-VP numbers from this lane's stripe, below the capacity limit. It writes each random block into a fresh region of the cache model with the stop bit on its last word. Random register indices stay below the sum of shared and private counts, so every physical address is one the split defines.

// File: rtl/vps_pkg.sv
package vps_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_RUN   = 2'd1,
    SEQ_EMPTY = 2'd2
  } seq_state_e;
endpackage

// File: rtl/vps_capacity.sv
module vps_capacity #(
  parameter int NUM_LANES = 4,
  parameter int LANE_ID   = 0,
  parameter int MAX_VP    = 128,
  parameter int PREGS     = 32,
  localparam int CNT_W      = $clog2(PREGS + 1),
  localparam int VL_W       = $clog2(MAX_VP + 1),
  localparam int LANE_SLOTS = MAX_VP / NUM_LANES,
  localparam int NSLOT_W    = $clog2(LANE_SLOTS + 1)
) (
  input  logic [CNT_W-1:0]   cfg_shared,
  input  logic [CNT_W-1:0]   cfg_private,
  input  logic [VL_W-1:0]    cfg_vlen,
  output logic [NSLOT_W-1:0] n_slots,
  output logic [VL_W-1:0]    max_vlen
);
  int avail;
  int fit;
  int need;

  // slots one lane can hold, limited by the register split
  always_comb begin
    if (int'(cfg_shared) >= PREGS) avail = 0;
    else                           avail = PREGS - int'(cfg_shared);
    if (cfg_private == '0)         fit = LANE_SLOTS;
    else                           fit = avail / int'(cfg_private);
    if (fit > LANE_SLOTS)          fit = LANE_SLOTS;
  end

  // VPs of this lane below the requested vector length
  always_comb begin
    if (int'(cfg_vlen) > LANE_ID) need = (int'(cfg_vlen) - LANE_ID - 1) / NUM_LANES + 1;
    else                          need = 0;
  end

  assign n_slots  = NSLOT_W'((need < fit) ? need : fit);
  assign max_vlen = VL_W'(fit * NUM_LANES);
endmodule

// File: rtl/vps_reg_map.sv
module vps_reg_map #(
  parameter int PREGS  = 32,
  parameter int VREG_W = 5,
  parameter int SLOT_W = 5,
  localparam int CNT_W  = $clog2(PREGS + 1),
  localparam int PREG_W = $clog2(PREGS)
) (
  input  logic [VREG_W-1:0] vreg,
  input  logic [SLOT_W-1:0] slot,
  input  logic [CNT_W-1:0]  cfg_shared,
  input  logic [CNT_W-1:0]  cfg_private,
  output logic [PREG_W-1:0] preg
);
  localparam int WIDE_W = VREG_W + SLOT_W + CNT_W + 2;
  logic [WIDE_W-1:0] vreg_w;
  logic [WIDE_W-1:0] shared_w;
  logic [WIDE_W-1:0] window_w;
  logic [WIDE_W-1:0] addr_w;

  assign vreg_w   = WIDE_W'(vreg);
  assign shared_w = WIDE_W'(cfg_shared);
  assign window_w = WIDE_W'(slot) * WIDE_W'(cfg_private);

  always_comb begin
    if (vreg_w < shared_w) addr_w = vreg_w;
    else                   addr_w = shared_w + window_w + (vreg_w - shared_w);
  end

  assign preg = addr_w[PREG_W-1:0];
endmodule

// File: rtl/vps_fsm.sv
module vps_fsm
  import vps_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int LANE_ID   = 0,
  parameter int MAX_VP    = 128,
  parameter int BADDR_W   = 8,
  localparam int VP_W       = $clog2(MAX_VP),
  localparam int LANE_SLOTS = MAX_VP / NUM_LANES,
  localparam int SLOT_W     = (LANE_SLOTS > 1) ? $clog2(LANE_SLOTS) : 1,
  localparam int NSLOT_W    = $clog2(LANE_SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dir_valid,
  input  logic               dir_vector,
  input  logic [VP_W-1:0]    dir_vp,
  input  logic [BADDR_W-1:0] dir_block,
  input  logic [NSLOT_W-1:0] n_slots,
  input  logic               word_stop,
  output logic               dir_ready,
  output logic               running,
  output logic               done,
  output logic [BADDR_W-1:0] pc,
  output logic [SLOT_W-1:0]  slot,
  output logic [VP_W-1:0]    cur_vp
);
  seq_state_e         state_q, state_d;
  logic [BADDR_W-1:0] pc_q, pc_d;
  logic [BADDR_W-1:0] base_q, base_d;
  logic [SLOT_W-1:0]  slot_q, slot_d;
  logic [SLOT_W-1:0]  last_q, last_d;
  logic               ctx_en;
  logic               accept;

  assign accept = (state_q == SEQ_IDLE) && dir_valid;

  always_comb begin
    state_d   = state_q;
    pc_d      = pc_q;
    base_d    = base_q;
    slot_d    = slot_q;
    last_d    = last_q;
    dir_ready = 1'b0;
    running   = 1'b0;
    done      = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        dir_ready = 1'b1;
        if (dir_valid) begin
          pc_d   = dir_block;
          base_d = dir_block;
          if (dir_vector) begin
            slot_d = '0;
            if (n_slots == '0) begin
              last_d  = '0;
              state_d = SEQ_EMPTY;
            end else begin
              last_d  = SLOT_W'(n_slots - 1'b1);
              state_d = SEQ_RUN;
            end
          end else begin
            slot_d  = SLOT_W'(int'(dir_vp) / NUM_LANES);
            last_d  = SLOT_W'(int'(dir_vp) / NUM_LANES);
            state_d = SEQ_RUN;
          end
        end
      end
      SEQ_RUN: begin
        running = 1'b1;
        if (word_stop) begin
          if (slot_q == last_q) begin
            done    = 1'b1;
            state_d = SEQ_IDLE;
          end else begin
            slot_d = slot_q + 1'b1;
            pc_d   = base_q;
          end
        end else begin
          pc_d = pc_q + 1'b1;
        end
      end
      SEQ_EMPTY: begin
        done    = 1'b1;
        state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  assign ctx_en = accept || (state_q == SEQ_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      base_q <= '0;
      slot_q <= '0;
      last_q <= '0;
    end else if (ctx_en) begin
      pc_q   <= pc_d;
      base_q <= base_d;
      slot_q <= slot_d;
      last_q <= last_d;
    end
  end

  assign pc     = pc_q;
  assign slot   = slot_q;
  assign cur_vp = VP_W'(int'(slot_q) * NUM_LANES + LANE_ID);
endmodule

// File: rtl/vp_exec_seq.sv
module vp_exec_seq #(
  parameter int NUM_LANES = 4,
  parameter int LANE_ID   = 0,
  parameter int MAX_VP    = 128,
  parameter int PREGS     = 32,
  parameter int VREG_W    = 5,
  parameter int BADDR_W   = 8,
  localparam int VP_W       = $clog2(MAX_VP),
  localparam int CNT_W      = $clog2(PREGS + 1),
  localparam int VL_W       = $clog2(MAX_VP + 1),
  localparam int PREG_W     = $clog2(PREGS),
  localparam int IW         = 2 + 2 * VREG_W + BADDR_W,
  localparam int LANE_SLOTS = MAX_VP / NUM_LANES,
  localparam int SLOT_W     = (LANE_SLOTS > 1) ? $clog2(LANE_SLOTS) : 1,
  localparam int NSLOT_W    = $clog2(LANE_SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cfg_shared,
  input  logic [CNT_W-1:0]   cfg_private,
  input  logic [VL_W-1:0]    cfg_vlen,
  output logic [VL_W-1:0]    max_vlen,
  input  logic               dir_valid,
  output logic               dir_ready,
  input  logic               dir_vector,
  input  logic [VP_W-1:0]    dir_vp,
  input  logic [BADDR_W-1:0] dir_block,
  output logic [BADDR_W-1:0] bc_addr,
  input  logic [IW-1:0]      bc_word,
  output logic               iss_valid,
  output logic [VP_W-1:0]    iss_vp,
  output logic [PREG_W-1:0]  iss_dst,
  output logic [PREG_W-1:0]  iss_src,
  output logic               tf_valid,
  output logic [VP_W-1:0]    tf_vp,
  output logic [BADDR_W-1:0] tf_block,
  output logic               dir_done
);
  // word fields: stop, thread-fetch, dst vreg, src vreg, target block
  localparam int STOP_BIT = IW - 1;
  localparam int TF_BIT   = IW - 2;
  localparam int DST_LSB  = BADDR_W + VREG_W;
  localparam int SRC_LSB  = BADDR_W;

  logic [NSLOT_W-1:0] n_slots;
  logic               running;
  logic [SLOT_W-1:0]  slot;
  logic [VP_W-1:0]    cur_vp;
  logic               word_stop;
  logic               word_tf;
  logic [VREG_W-1:0]  vreg_sel [2];
  logic [PREG_W-1:0]  preg_sel [2];

  assign word_stop   = bc_word[STOP_BIT];
  assign word_tf     = bc_word[TF_BIT];
  assign vreg_sel[0] = bc_word[DST_LSB +: VREG_W];
  assign vreg_sel[1] = bc_word[SRC_LSB +: VREG_W];

  vps_capacity #(
    .NUM_LANES(NUM_LANES), .LANE_ID(LANE_ID), .MAX_VP(MAX_VP), .PREGS(PREGS)
  ) i_capacity (
    .cfg_shared (cfg_shared),
    .cfg_private(cfg_private),
    .cfg_vlen   (cfg_vlen),
    .n_slots    (n_slots),
    .max_vlen   (max_vlen)
  );

  vps_fsm #(
    .NUM_LANES(NUM_LANES), .LANE_ID(LANE_ID), .MAX_VP(MAX_VP), .BADDR_W(BADDR_W)
  ) i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_valid (dir_valid),
    .dir_vector(dir_vector),
    .dir_vp    (dir_vp),
    .dir_block (dir_block),
    .n_slots   (n_slots),
    .word_stop (word_stop),
    .dir_ready (dir_ready),
    .running   (running),
    .done      (dir_done),
    .pc        (bc_addr),
    .slot      (slot),
    .cur_vp    (cur_vp)
  );

  // one mapper per register operand (0: destination, 1: source)
  for (genvar g = 0; g < 2; g++) begin : g_map
    vps_reg_map #(
      .PREGS(PREGS), .VREG_W(VREG_W), .SLOT_W(SLOT_W)
    ) i_map (
      .vreg       (vreg_sel[g]),
      .slot       (slot),
      .cfg_shared (cfg_shared),
      .cfg_private(cfg_private),
      .preg       (preg_sel[g])
    );
  end

  assign iss_valid = running && !word_tf;
  assign iss_vp    = cur_vp;
  assign iss_dst   = preg_sel[0];
  assign iss_src   = preg_sel[1];
  assign tf_valid  = running && word_tf;
  assign tf_vp     = cur_vp;
  assign tf_block  = bc_word[BADDR_W-1:0];
endmodule

// File: rtl/vp_exec_seq_chk.sv
module vp_exec_seq_chk #(
  parameter int NUM_LANES = 4,
  parameter int LANE_ID   = 0,
  parameter int MAX_VP    = 128,
  parameter int PREGS     = 32,
  parameter int VREG_W    = 5,
  parameter int BADDR_W   = 8,
  localparam int VP_W   = $clog2(MAX_VP),
  localparam int CNT_W  = $clog2(PREGS + 1),
  localparam int VL_W   = $clog2(MAX_VP + 1),
  localparam int PREG_W = $clog2(PREGS),
  localparam int IW     = 2 + 2 * VREG_W + BADDR_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CNT_W-1:0]   cfg_shared,
  input logic [VL_W-1:0]    max_vlen,
  input logic               dir_valid,
  input logic               dir_ready,
  input logic [BADDR_W-1:0] dir_block,
  input logic [BADDR_W-1:0] bc_addr,
  input logic [IW-1:0]      bc_word,
  input logic               iss_valid,
  input logic [VP_W-1:0]    iss_vp,
  input logic [PREG_W-1:0]  iss_src,
  input logic               tf_valid,
  input logic [VP_W-1:0]    tf_vp,
  input logic               dir_done
);
  logic               act;
  logic               stop;
  logic [VP_W-1:0]    act_vp;
  logic [BADDR_W-1:0] start_q;
  logic [VREG_W-1:0]  src_v;

  assign act    = iss_valid || tf_valid;
  assign stop   = bc_word[IW-1];
  assign act_vp = tf_valid ? tf_vp : iss_vp;
  assign src_v  = bc_word[BADDR_W +: VREG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      start_q <= '0;
    else if (dir_valid && dir_ready) start_q <= dir_block;
  end

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(iss_valid && tf_valid)); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> !dir_ready); // R10
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    dir_done |=> dir_ready); // R10
  AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_valid && dir_ready) |=> (!act || bc_addr == start_q)); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !stop) |=> (act && bc_addr == $past(bc_addr) + 1'b1)); // R2
  AST_SAME_VP_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !stop) |=> (act_vp == $past(act_vp))); // R3
  AST_NEXT_VP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (act && stop && !dir_done) |=>
      (act && bc_addr == start_q && act_vp == $past(act_vp) + VP_W'(NUM_LANES))); // R3
  AST_VP_ON_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (int'(act_vp) % NUM_LANES == LANE_ID)); // R3
  AST_SHARED_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && CNT_W'(src_v) < cfg_shared) |-> (PREG_W'(src_v) == iss_src)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dir_done |=> !dir_done); // R9
  AST_MAX_VLEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(max_vlen) <= MAX_VP) && (int'(max_vlen) % NUM_LANES == 0)); // R8
endmodule

bind vp_exec_seq vp_exec_seq_chk #(
  .NUM_LANES(NUM_LANES), .LANE_ID(LANE_ID), .MAX_VP(MAX_VP),
  .PREGS(PREGS), .VREG_W(VREG_W), .BADDR_W(BADDR_W)
) i_vp_exec_seq_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_shared(cfg_shared),
  .max_vlen  (max_vlen),
  .dir_valid (dir_valid),
  .dir_ready (dir_ready),
  .dir_block (dir_block),
  .bc_addr   (bc_addr),
  .bc_word   (bc_word),
  .iss_valid (iss_valid),
  .iss_vp    (iss_vp),
  .iss_src   (iss_src),
  .tf_valid  (tf_valid),
  .tf_vp     (tf_vp),
  .dir_done  (dir_done)
);

// File: tb/test_vp_exec_seq.sv
`timescale 1ns/1ps
module test_vp_exec_seq;
  localparam int NL = 4;
  localparam int LN = 1;
  localparam int MV = 128;
  localparam int PR = 32;

  logic        clk;
  logic        rst_n;
  logic [5:0]  cfg_shared;
  logic [5:0]  cfg_private;
  logic [7:0]  cfg_vlen;
  logic [7:0]  max_vlen;
  logic        dir_valid;
  logic        dir_ready;
  logic        dir_vector;
  logic [6:0]  dir_vp;
  logic [7:0]  dir_block;
  logic [7:0]  bc_addr;
  logic [19:0] bc_word;
  logic        iss_valid;
  logic [6:0]  iss_vp;
  logic [4:0]  iss_dst;
  logic [4:0]  iss_src;
  logic        tf_valid;
  logic [6:0]  tf_vp;
  logic [7:0]  tf_block;
  logic        dir_done;

  logic [19:0] mem [256];
  int n_checks;
  int n_fail;
  int next_free;

  assign bc_word = mem[bc_addr];

  vp_exec_seq #(.NUM_LANES(NL), .LANE_ID(LN), .MAX_VP(MV), .PREGS(PR)) i_vp_exec_seq (
    .clk(clk), .rst_n(rst_n), .cfg_shared(cfg_shared), .cfg_private(cfg_private),
    .cfg_vlen(cfg_vlen), .max_vlen(max_vlen), .dir_valid(dir_valid), .dir_ready(dir_ready),
    .dir_vector(dir_vector), .dir_vp(dir_vp), .dir_block(dir_block), .bc_addr(bc_addr),
    .bc_word(bc_word), .iss_valid(iss_valid), .iss_vp(iss_vp), .iss_dst(iss_dst),
    .iss_src(iss_src), .tf_valid(tf_valid), .tf_vp(tf_vp), .tf_block(tf_block),
    .dir_done(dir_done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int slots_fit(input int sh, input int pv);
    int avail = (sh >= PR) ? 0 : PR - sh;
    int f = (pv == 0) ? MV / NL : avail / pv;
    return (f > MV / NL) ? MV / NL : f;
  endfunction

  function automatic int lane_vps(input int vl, input int sh, input int pv);
    int lim = slots_fit(sh, pv) * NL;
    int v = (vl < lim) ? vl : lim;
    return (v > LN) ? (v - LN - 1) / NL + 1 : 0;
  endfunction

  function automatic int map_reg(input int r, input int sh, input int pv, input int k);
    return (r < sh) ? r : ((sh + k * pv + r - sh) & (PR - 1));
  endfunction

  task automatic set_cfg(input int sh, input int pv, input int vl);
    @(negedge clk);
    cfg_shared  = 6'(sh);
    cfg_private = 6'(pv);
    cfg_vlen    = 8'(vl);
    #1;
    check(int'(max_vlen) == slots_fit(sh, pv) * NL, "R8 max_vlen", int'(max_vlen), slots_fit(sh, pv) * NL);
  endtask

  // writes a block of len words at a fresh address; returns its base
  task automatic make_block(input int len, input int sh, input int pv, input int tf_pct,
                            output int base);
    int lim = (sh + pv > 0) ? sh + pv : 1;
    base = next_free;
    for (int i = 0; i < len; i++) begin
      logic [19:0] w;
      w[19]    = (i == len - 1);
      w[18]    = (int'($urandom % 100) < tf_pct);
      w[17:13] = 5'($urandom % lim);
      w[12:8]  = 5'($urandom % lim);
      w[7:0]   = 8'($urandom);
      mem[(base + i) & 255] = w;
    end
    next_free = (next_free + len) & 255;
  endtask

  task automatic run_dir(input bit vec, input int vp, input int base, input int len);
    int exp_q[$];
    int obs_q[$];
    int nvp;
    int cycles;
    int first_addr;
    int sh = int'(cfg_shared);
    int pv = int'(cfg_private);
    bit got_done;
    bit mismatch;
    nvp = vec ? lane_vps(int'(cfg_vlen), sh, pv) : 1;
    for (int k = 0; k < nvp; k++) begin
      int v = vec ? k * NL + LN : vp;
      int slot = v / NL;
      for (int i = 0; i < len; i++) begin
        logic [19:0] w = mem[(base + i) & 255];
        if (w[18]) exp_q.push_back((1 << 30) | (v << 16) | int'(w[7:0]));
        else exp_q.push_back((v << 16) | (map_reg(int'(w[17:13]), sh, pv, slot) << 8)
                             | map_reg(int'(w[12:8]), sh, pv, slot));
      end
    end
    @(negedge clk);
    check(dir_ready == 1'b1, "R10 ready before directive", int'(dir_ready), 1);
    dir_valid  = 1'b1;
    dir_vector = vec;
    dir_vp     = 7'(vp);
    dir_block  = 8'(base);
    cycles = 0; got_done = 0; first_addr = -1;
    while (!got_done && cycles < 400) begin
      @(negedge clk);
      dir_valid = 1'b0;
      cycles++;
      if (cycles == 1) first_addr = int'(bc_addr);
      if (iss_valid || tf_valid) begin
        if (dir_ready) check(0, "R10 ready low while busy", 1, 0);
        if (tf_valid) obs_q.push_back((1 << 30) | (int'(tf_vp) << 16) | int'(tf_block));
        else obs_q.push_back((int'(iss_vp) << 16) | (int'(iss_dst) << 8) | int'(iss_src));
        if (iss_valid && tf_valid) check(0, "R7 both valid", 1, 0);
      end
      got_done = dir_done;
    end
    check(got_done, "R9 done seen", int'(got_done), 1);
    check(cycles == ((nvp == 0) ? 1 : nvp * len), "R2 R9 cycle count", cycles,
          (nvp == 0) ? 1 : nvp * len);
    if (nvp > 0) check(first_addr == base, "R2 first address", first_addr, base);
    check(obs_q.size() == exp_q.size(), vec ? "R3 R8 op count" : "R4 op count",
          obs_q.size(), exp_q.size());
    mismatch = 0;
    for (int i = 0; i < obs_q.size() && i < exp_q.size(); i++)
      if (!mismatch && obs_q[i] != exp_q[i]) begin
        mismatch = 1;
        check(0, "R3 R4 R5 R6 R7 op content", obs_q[i], exp_q[i]);
      end
    if (!mismatch) check(1, "R5 R6 R7 op content", 0, 0);
    @(negedge clk);
    check(dir_ready && !dir_done, "R10 R9 idle after done", int'(dir_ready), 1);
  endtask

  initial begin
    int b;
    int seed;
    n_checks = 0; n_fail = 0; next_free = 0;
    seed = $urandom(32'h5eed_1234);
    for (int i = 0; i < 256; i++) mem[i] = 20'h80000;
    rst_n = 1'b0; dir_valid = 1'b0; dir_vector = 1'b0; dir_vp = '0; dir_block = '0;
    cfg_shared = 6'd4; cfg_private = 6'd4; cfg_vlen = 8'd8;
    repeat (3) @(negedge clk);
    check(dir_ready && !iss_valid && !tf_valid && !dir_done, "R1 reset outputs",
          int'({dir_ready, iss_valid, tf_valid, dir_done}), 8);
    rst_n = 1'b1;
    @(negedge clk);
    check(dir_ready && !dir_done, "R1 idle after release", int'(dir_ready), 1);

    // zero vector length, and a length that reaches only lane 0: R9 empty
    set_cfg(4, 4, 0);
    make_block(3, 4, 4, 0, b); run_dir(1, 0, b, 3);
    set_cfg(4, 4, 1); run_dir(1, 0, b, 3);
    // exactly one VP on this lane: R3
    set_cfg(4, 4, 2); run_dir(1, 0, b, 3);
    // single-VP directive to slot 2: R4
    set_cfg(2, 6, 20);
    make_block(4, 2, 6, 30, b); run_dir(0, 9, b, 4);
    // capacity clamp: 3 slots fit, vector length far larger: R8
    set_cfg(8, 8, 128);
    make_block(2, 8, 8, 0, b); run_dir(1, 0, b, 2);
    // shared only: R5, R8
    set_cfg(32, 0, 128);
    make_block(1, 32, 0, 0, b); run_dir(1, 0, b, 1);
    // all thread-fetch block: R7
    set_cfg(0, 1, 12);
    make_block(2, 0, 1, 100, b); run_dir(1, 0, b, 2);

    for (int n = 0; n < 40; n++) begin
      int sh = int'($urandom % 9);
      int pv = int'($urandom % 7);
      int vl = int'($urandom % 129);
      int len = 1 + int'($urandom % 5);
      int cap;
      bit vec = ($urandom % 4) != 0;
      int vp;
      set_cfg(sh, pv, vl);
      cap = slots_fit(sh, pv);
      if (cap == 0) vec = 1;
      vp = (cap > 0) ? int'($urandom % cap) * NL + LN : LN;
      make_block(len, sh, pv, 20, b);
      run_dir(vec, vp, b, len);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule